// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Oscillator Status

This block is the timekeeping core that sits behind a real-time-clock register bank. It holds the current time and date as packed BCD bytes: seconds, minutes, hours, day of week, day of month, month and year. Software reaches it through a byte-wide write strobe with a register index and through a read index that selects which byte appears on the read port. A one-second tick, generated elsewhere, advances the calendar, but only while a start bit inside the seconds byte is set.

Two flags report hardware state and cannot be written. A running flag, in the day-of-week byte, mirrors the oscillator. It drops a fixed number of clock cycles after software clears the start bit, so a driver that polls it after stopping the clock sees it fall within its polling window. It comes back a fixed number of ticks after the start bit is set again. A leap-year flag, in the month byte, is derived from the year and sets February's length. The hours byte carries a 12/24-hour mode bit. A spare control byte holds an external-oscillator select bit for the crystal logic outside this block.

Writes are stored as given, with no check against other fields. This lets software load the time in one burst and the month and year in a second burst without the date being altered in between.

Top module: `rtcc_timekeeper`

## Requirements
- R1: Bit 7 of the seconds byte (index 0) is the start bit, and bits 6:0 are BCD seconds. The calendar advances by one second on a cycle with `sec_tick` high only while the start bit is 1. With the start bit at 0, a tick changes no time field.
- R2: Seconds and minutes (index 1, bits 6:0) count 00 to 59. Seconds wrap 59 to 00 and carry into minutes, and minutes wrap 59 to 00 and carry into hours.
- R3: With hours bit 6 at 0 (24-hour mode), hours (index 2, bits 5:0) count 00 to 23, and 23 wraps to 00 with a carry into the day.
- R4: With hours bit 6 at 1 (12-hour mode), bit 5 is PM and bits 4:0 hold 01 to 12. A step from 11 gives 12 and toggles PM, and 12 steps to 01. The day carries only on the step from 11 PM to 12 AM.
- R5: The day of week (index 3, bits 2:0) steps 1 to 7 on each day carry, and 7 wraps to 1.
- R6: The date (index 4, bits 5:0) wraps to 01 after the last day of the month and carries into the month. Months 04, 06, 09 and 11 have 30 days, month 02 has 28 days (29 when the leap flag is set), and all other months have 31 days. The month (index 5, bits 4:0) wraps 12 to 01 and carries into the year. The year (index 6, full byte) wraps 99 to 00.
- R7: Month bit 5 is a read-only leap flag. It reads 1 exactly when the BCD year is divisible by four, and a write to that bit has no effect.
- R8: Day-of-week bit 5 is a read-only running flag. It falls STOP_CYCLES clock cycles after the start bit is cleared, and it rises on the START_TICKS-th tick counted while the start bit is set. A write to that bit has no effect.
- R9: The control byte (index 7) is readable and writable in full. Its bit 3 is the external-oscillator select.
- R10: A written field keeps the written value even when a tick arrives in the same cycle. Writing the month or the year never changes the date.
- R11: After reset the block reads: seconds 0x00 (stopped), minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x21 (year 00 is a leap year), year 0x00, control 0x00, with the running flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one register byte |
| wr_addr | input | 3 | Index of the register written |
| wr_data | input | 8 | Byte written |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| rd_addr | input | 3 | Index of the register shown on rd_data |
| rd_data | output | 8 | Byte read, combinational from rd_addr |

## Verification
Properties check the following on every cycle:
- The seconds byte holds its value without a tick or while the clock is stopped.
- Seconds wrap from 59 to 00.
- The 24-hour wrap occurs at midnight.
- A month write leaves the date alone.
- The running flag never rises while the clock is stopped, never falls while it is started, and rises only on a tick.

The bench scenarios cover the rest:
- The month-length table across 28, 29, 30 and 31 days.
- The year and month wraps.
- The 12-hour PM sequence.
- The exact cycle at which the running flag falls.
- That writes to the two read-only flags have no effect.

// File: rtl/rtcc_pkg.sv
// Shared constants and BCD helpers for the calendar timekeeper.
// Assumes all stored fields are packed BCD; helpers tolerate invalid codes
// without locking up (they simply wrap on the compare limits).
package rtcc_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] IDX_SEC   = 3'd0;
    localparam logic [ADDR_W-1:0] IDX_MIN   = 3'd1;
    localparam logic [ADDR_W-1:0] IDX_HOUR  = 3'd2;
    localparam logic [ADDR_W-1:0] IDX_WDAY  = 3'd3;
    localparam logic [ADDR_W-1:0] IDX_DATE  = 3'd4;
    localparam logic [ADDR_W-1:0] IDX_MONTH = 3'd5;
    localparam logic [ADDR_W-1:0] IDX_YEAR  = 3'd6;
    localparam logic [ADDR_W-1:0] IDX_CTRL  = 3'd7;

    // Increment a two-digit BCD byte by one (99 wraps to 00).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [3:0] lo;
        logic [3:0] hi;
        if (v[3:0] >= 4'd9) begin
            lo = 4'd0;
            hi = (v[7:4] >= 4'd9) ? 4'd0 : v[7:4] + 4'd1;
        end else begin
            lo = v[3:0] + 4'd1;
            hi = v[7:4];
        end
        return {hi, lo};
    endfunction

    // A BCD year is divisible by four when tens parity and units agree.
    function automatic logic year_is_leap(input logic [7:0] y);
        if (y[4] == 1'b0)
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        else
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    // Last valid BCD day of a BCD month.
    function automatic logic [5:0] last_day(input logic [4:0] m, input logic leap);
        case (m)
            5'h02:                         return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11:    return 6'h30;
            default:                       return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtcc_osc_status.sv
// Oscillator running-status model.
// Drops the running flag STOP_CYCLES clocks after the start bit is cleared
// and raises it on the START_TICKS-th second tick seen with the start bit set.
// Assumes START_TICKS >= 1 and STOP_CYCLES >= 1.
module rtcc_osc_status #(
    parameter int unsigned START_TICKS = 2,
    parameter int unsigned STOP_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_bit,
    input  logic sec_tick,
    output logic running
);
    localparam int unsigned CNT_MAX = (START_TICKS > STOP_CYCLES) ? START_TICKS : STOP_CYCLES;
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] START_LAST = CW'(START_TICKS - 1);
    localparam logic [CW-1:0] STOP_LAST  = CW'(STOP_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count either ticks (spinning up) or cycles (spinning down) toward a flag change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            running <= 1'b0;
        end else if (start_bit && !running) begin
            if (sec_tick) begin
                if (cnt_q >= START_LAST) begin
                    cnt_q   <= '0;
                    running <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end else if (!start_bit && running) begin
            if (cnt_q >= STOP_LAST) begin
                cnt_q   <= '0;
                running <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/rtcc_time_chain.sv
// Seconds, minutes and hours counters with the start bit.
// Advances on sec_tick only while the start bit is set; a write to a field
// takes priority over its increment in the same cycle. Emits a one-cycle
// day carry (combinational) on the midnight step in either hour mode.
module rtcc_time_chain
    import rtcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       wr_sec,
    input  logic       wr_min,
    input  logic       wr_hour,
    input  logic [7:0] wdata,
    output logic [7:0] sec_q,
    output logic [6:0] min_q,
    output logic [6:0] hour_q,
    output logic       day_carry
);
    logic       adv;
    logic       sec_wrap;
    logic       min_wrap;
    logic [6:0] sec_next;
    logic [6:0] min_next;
    logic [6:0] hour_next;
    logic       hour_wrap;

    assign adv      = sec_tick && sec_q[7];
    assign sec_wrap = (sec_q[6:0] >= 7'h59);
    assign min_wrap = (min_q >= 7'h59);

    // Next seconds and minutes values in BCD.
    always_comb begin
        sec_next = sec_wrap ? 7'h00 : 7'(bcd_inc({1'b0, sec_q[6:0]}));
        min_next = min_wrap ? 7'h00 : 7'(bcd_inc({1'b0, min_q}));
    end

    // Next hours value and day carry for the selected hour mode.
    always_comb begin
        hour_next = hour_q;
        hour_wrap = 1'b0;
        if (hour_q[6]) begin
            if (hour_q[4:0] == 5'h11) begin
                hour_next = {1'b1, ~hour_q[5], 5'h12};
                hour_wrap = hour_q[5];
            end else if (hour_q[4:0] >= 5'h12) begin
                hour_next = {1'b1, hour_q[5], 5'h01};
            end else begin
                hour_next = {1'b1, hour_q[5], 5'(bcd_inc({3'b000, hour_q[4:0]}))};
            end
        end else begin
            if (hour_q[5:0] >= 6'h23) begin
                hour_next = 7'h00;
                hour_wrap = 1'b1;
            end else begin
                hour_next = {1'b0, 6'(bcd_inc({2'b00, hour_q[5:0]}))};
            end
        end
    end

    assign day_carry = adv && sec_wrap && min_wrap && hour_wrap;

    // Seconds register with its start bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       sec_q <= 8'h00;
        else if (wr_sec)  sec_q <= wdata;
        else if (adv)     sec_q <= {sec_q[7], sec_next};
    end

    // Minutes register.
    always_ff @(posedge clk) begin
        if (!rst_n)                min_q <= 7'h00;
        else if (wr_min)           min_q <= wdata[6:0];
        else if (adv && sec_wrap)  min_q <= min_next;
    end

    // Hours register with mode and PM bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                            hour_q <= 7'h00;
        else if (wr_hour)                      hour_q <= wdata[6:0];
        else if (adv && sec_wrap && min_wrap)  hour_q <= hour_next;
    end

endmodule

// File: rtl/rtcc_date_chain.sv
// Day-of-week, date, month and year counters driven by the day carry.
// Month length follows the hardware leap flag derived from the year.
// Writes are stored verbatim and never re-validated against other fields.
module rtcc_date_chain
    import rtcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       day_carry,
    input  logic       wr_wday,
    input  logic       wr_date,
    input  logic       wr_month,
    input  logic       wr_year,
    input  logic [7:0] wdata,
    output logic [2:0] wday_q,
    output logic [5:0] date_q,
    output logic [4:0] month_q,
    output logic [7:0] year_q,
    output logic       leap
);
    logic date_wrap;
    logic month_wrap;

    assign leap       = year_is_leap(year_q);
    assign date_wrap  = (date_q >= last_day(month_q, leap));
    assign month_wrap = (month_q >= 5'h12);

    // Day of week cycles 1..7.
    always_ff @(posedge clk) begin
        if (!rst_n)          wday_q <= 3'd1;
        else if (wr_wday)    wday_q <= wdata[2:0];
        else if (day_carry)  wday_q <= (wday_q >= 3'd7) ? 3'd1 : wday_q + 3'd1;
    end

    // Date wraps at the month length.
    always_ff @(posedge clk) begin
        if (!rst_n)          date_q <= 6'h01;
        else if (wr_date)    date_q <= wdata[5:0];
        else if (day_carry)  date_q <= date_wrap ? 6'h01 : 6'(bcd_inc({2'b00, date_q}));
    end

    // Month wraps 12 to 01.
    always_ff @(posedge clk) begin
        if (!rst_n)                       month_q <= 5'h01;
        else if (wr_month)                month_q <= wdata[4:0];
        else if (day_carry && date_wrap)  month_q <= month_wrap ? 5'h01 : 5'(bcd_inc({3'b000, month_q}));
    end

    // Year wraps 99 to 00.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     year_q <= 8'h00;
        else if (wr_year)                               year_q <= wdata;
        else if (day_carry && date_wrap && month_wrap)  year_q <= bcd_inc(year_q);
    end

endmodule

// File: rtl/rtcc_timekeeper.sv
// Top of the BCD calendar timekeeper.
// Decodes byte writes to eight register indices, hosts the control byte,
// combines the read-only running and leap flags into the read view.
// Assumes sec_tick is a single-cycle pulse at most once per second.
module rtcc_timekeeper
    import rtcc_pkg::*;
#(
    parameter int unsigned START_TICKS = 2,
    parameter int unsigned STOP_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              sec_tick,
    input  logic [2:0]        rd_addr,
    output logic [7:0]        rd_data
);
    logic [7:0] wr_sel;
    logic [7:0] sec_q;
    logic [6:0] min_q;
    logic [6:0] hr_q;
    logic       day_carry;
    logic [2:0] wday_q;
    logic [5:0] date_q;
    logic [4:0] month_q;
    logic [7:0] year_q;
    logic       leap;
    logic       osc_running;
    logic [7:0] ctrl_q;

    // One strobe per register index.
    genvar gi;
    generate
        for (gi = 0; gi < 8; gi++) begin : g_wsel
            assign wr_sel[gi] = wr_en && (wr_addr == ADDR_W'(gi));
        end
    endgenerate

    rtcc_time_chain u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .wr_sec    (wr_sel[IDX_SEC]),
        .wr_min    (wr_sel[IDX_MIN]),
        .wr_hour   (wr_sel[IDX_HOUR]),
        .wdata     (wr_data),
        .sec_q     (sec_q),
        .min_q     (min_q),
        .hour_q    (hr_q),
        .day_carry (day_carry)
    );

    rtcc_date_chain u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .day_carry (day_carry),
        .wr_wday   (wr_sel[IDX_WDAY]),
        .wr_date   (wr_sel[IDX_DATE]),
        .wr_month  (wr_sel[IDX_MONTH]),
        .wr_year   (wr_sel[IDX_YEAR]),
        .wdata     (wr_data),
        .wday_q    (wday_q),
        .date_q    (date_q),
        .month_q   (month_q),
        .year_q    (year_q),
        .leap      (leap)
    );

    rtcc_osc_status #(
        .START_TICKS (START_TICKS),
        .STOP_CYCLES (STOP_CYCLES)
    ) u_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_bit (sec_q[7]),
        .sec_tick  (sec_tick),
        .running   (osc_running)
    );

    // Control byte, bit 3 selects the external oscillator source.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ctrl_q <= 8'h00;
        else if (wr_sel[IDX_CTRL])  ctrl_q <= wr_data;
    end

    // Read view with the hardware-owned flags merged in.
    always_comb begin
        case (rd_addr)
            IDX_SEC:   rd_data = sec_q;
            IDX_MIN:   rd_data = {1'b0, min_q};
            IDX_HOUR:  rd_data = {1'b0, hr_q};
            IDX_WDAY:  rd_data = {2'b00, osc_running, 2'b00, wday_q};
            IDX_DATE:  rd_data = {2'b00, date_q};
            IDX_MONTH: rd_data = {2'b00, leap, month_q};
            IDX_YEAR:  rd_data = year_q;
            default:   rd_data = ctrl_q;
        endcase
    end

endmodule

// File: rtl/rtcc_timekeeper_chk.sv
// Temporal checks on the timekeeper, attached by bind.
module rtcc_timekeeper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic       sec_tick,
    input logic [7:0] sec_q,
    input logic [6:0] min_q,
    input logic [6:0] hr_q,
    input logic [5:0] date_q,
    input logic       running
);
    // R1: no tick and no seconds write leaves seconds alone
    a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !(wr_en && wr_addr == 3'd0)) |=> $stable(sec_q));

    // R1: stopped clock holds seconds even with a tick
    a_r1_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_q[7] && !(wr_en && wr_addr == 3'd0)) |=> $stable(sec_q));

    // R2: seconds wrap 59 to 00
    a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && sec_q == 8'hD9 && !(wr_en && wr_addr == 3'd0)) |=> (sec_q == 8'h80));

    // R3: midnight wrap in 24-hour mode
    a_r3_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && sec_q == 8'hD9 && min_q == 7'h59 && hr_q == 7'h23 && !wr_en) |=> (hr_q == 7'h00));

    // R10: month write does not touch the date
    a_r10_month_keeps_date: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd5 && !sec_tick) |=> $stable(date_q));

    // R8: running flag never rises while stopped
    a_r8_no_rise_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_q[7] |=> !$rose(running));

    // R8: running flag never falls while started
    a_r8_no_fall_started: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q[7] |=> !$fell(running));

    // R8: running flag rises only on a tick
    a_r8_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(sec_tick));

endmodule

bind rtcc_timekeeper rtcc_timekeeper_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .sec_tick (sec_tick),
    .sec_q    (sec_q),
    .min_q    (min_q),
    .hr_q     (hr_q),
    .date_q   (date_q),
    .running  (osc_running)
);

// File: tb/sim_rtcc_timekeeper.sv
`timescale 1ns/1ps
module sim_rtcc_timekeeper;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sec_tick = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rtcc_timekeeper #(.START_TICKS(2), .STOP_CYCLES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sec_tick(sec_tick), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    localparam logic [1:0] OW = 2'd0;
    localparam logic [1:0] OT = 2'd1;
    localparam logic [1:0] OC = 2'd2;
    localparam int NV = 60;
    // {op, index, data}: write, tick, or check of a read byte
    localparam logic [12:0] VEC [NV] = '{
        {OW,3'd3,8'h07}, {OW,3'd4,8'h28}, {OW,3'd5,8'h02}, {OW,3'd6,8'h23},
        {OW,3'd2,8'h23}, {OW,3'd1,8'h59}, {OW,3'd0,8'hD8}, {OT,3'd0,8'h00},
        {OC,3'd0,8'hD9}, {OT,3'd0,8'h00}, {OC,3'd0,8'h80}, {OC,3'd1,8'h00},
        {OC,3'd2,8'h00}, {OC,3'd3,8'h21}, {OC,3'd4,8'h01}, {OC,3'd5,8'h03},
        {OW,3'd6,8'h24}, {OC,3'd5,8'h23}, {OW,3'd5,8'h02}, {OW,3'd4,8'h28},
        {OW,3'd2,8'h23}, {OW,3'd1,8'h59}, {OW,3'd0,8'hD9}, {OT,3'd0,8'h00},
        {OC,3'd4,8'h29}, {OC,3'd5,8'h22}, {OW,3'd6,8'h99}, {OW,3'd5,8'h12},
        {OW,3'd4,8'h31}, {OW,3'd2,8'h23}, {OW,3'd1,8'h59}, {OW,3'd0,8'hD9},
        {OT,3'd0,8'h00}, {OC,3'd6,8'h00}, {OC,3'd5,8'h21}, {OC,3'd4,8'h01},
        {OW,3'd2,8'h51}, {OW,3'd1,8'h59}, {OW,3'd0,8'hD9}, {OT,3'd0,8'h00},
        {OC,3'd2,8'h72}, {OW,3'd2,8'h71}, {OW,3'd1,8'h59}, {OW,3'd0,8'hD9},
        {OT,3'd0,8'h00}, {OC,3'd2,8'h52}, {OC,3'd4,8'h02}, {OW,3'd2,8'h52},
        {OW,3'd1,8'h59}, {OW,3'd0,8'hD9}, {OT,3'd0,8'h00}, {OC,3'd2,8'h41},
        {OW,3'd5,8'h04}, {OW,3'd4,8'h30}, {OW,3'd2,8'h23}, {OW,3'd1,8'h59},
        {OW,3'd0,8'hD9}, {OT,3'd0,8'h00}, {OC,3'd4,8'h01}, {OC,3'd5,8'h25}
    };

    task automatic do_write(input logic [2:0] a, input logic [7:0] d, input logic tk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; sec_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic check(input logic [2:0] a, input logic [7:0] mask,
                         input logic [7:0] exp, input string req);
        rd_addr = a;
        #1;
        n_checks++;
        if ((rd_data & mask) !== exp) begin
            n_fail++;
            $display("FAIL %s idx %0d: got %02h expected %02h", req, a, rd_data & mask, exp);
        end
    endtask

    // Names the requirement each table entry exercises, by register index.
    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset view
        check(3'd0, 8'hFF, 8'h00, "R11");
        check(3'd1, 8'hFF, 8'h00, "R11");
        check(3'd2, 8'hFF, 8'h00, "R11");
        check(3'd3, 8'hFF, 8'h01, "R11");
        check(3'd4, 8'hFF, 8'h01, "R11");
        check(3'd5, 8'hFF, 8'h21, "R11");
        check(3'd6, 8'hFF, 8'h00, "R11");
        check(3'd7, 8'hFF, 8'h00, "R11");

        // Table walk: R1 R2 R3 R4 R5 R6 R7 scenarios
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][12:11])
                OW:      do_write(VEC[i][10:8], VEC[i][7:0], 1'b0);
                OT:      do_tick();
                default: check(VEC[i][10:8], 8'hFF, VEC[i][7:0], tag_of(VEC[i][10:8]));
            endcase
        end

        // R8: running flag falls exactly STOP_CYCLES after the stop write
        do_write(3'd0, 8'h00, 1'b0);
        check(3'd3, 8'h20, 8'h20, "R8");
        repeat (3) @(negedge clk);
        check(3'd3, 8'h20, 8'h20, "R8");
        @(negedge clk);
        check(3'd3, 8'h20, 8'h00, "R8");
        // R1: tick while stopped does not advance
        do_tick();
        check(3'd0, 8'hFF, 8'h00, "R1");
        // R8: write to running bit ignored
        do_write(3'd3, 8'h26, 1'b0);
        check(3'd3, 8'hFF, 8'h06, "R8");
        // R8: rises on second tick after restart
        do_write(3'd0, 8'h80, 1'b0);
        do_tick();
        check(3'd3, 8'h20, 8'h00, "R8");
        do_tick();
        check(3'd3, 8'h20, 8'h20, "R8");
        // R10: write wins over same-cycle tick
        do_write(3'd0, 8'h85, 1'b1);
        check(3'd0, 8'hFF, 8'h85, "R10");
        // R10: burst date then month keeps the date
        do_write(3'd4, 8'h31, 1'b0);
        do_write(3'd5, 8'h02, 1'b0);
        check(3'd4, 8'hFF, 8'h31, "R10");
        // R7: leap bit write ignored, follows year
        do_write(3'd5, 8'h03, 1'b0);
        check(3'd5, 8'hFF, 8'h23, "R7");
        do_write(3'd6, 8'h01, 1'b0);
        check(3'd5, 8'hFF, 8'h03, "R7");
        // R9: control byte fully writable
        do_write(3'd7, 8'h08, 1'b0);
        check(3'd7, 8'hFF, 8'h08, "R9");
        do_write(3'd7, 8'hF7, 1'b0);
        check(3'd7, 8'hFF, 8'hF7, "R9");
        // R5: day of week 7 wraps to 1 at midnight
        do_write(3'd3, 8'h07, 1'b0);
        do_write(3'd2, 8'h23, 1'b0);
        do_write(3'd1, 8'h59, 1'b0);
        do_write(3'd0, 8'hD9, 1'b0);
        do_tick();
        check(3'd3, 8'h07, 8'h01, "R5");
        // R3: hours wrapped to 00
        check(3'd2, 8'hFF, 8'h00, "R3");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule